// File: doc/BRIEF.md
# Pixelwise Priority Bus Arbitration Master

This block is the arbitration agent that one video source uses on a shared picture bus. Up to eight sources compete for the bus pixel by pixel over a 3-bit priority lane. On each clock edge where the agent requests, it places its own priority code on the lane. During the same cycle it compares the resolved lane value with that code. It enables its luma and chroma outputs only when the two are equal. The lane is resolved outside the block. In this project it is a wired-OR of every agent's driven code, so a lane value that matches no agent means every agent stays off the bus.

Two request policies are available. In the gated policy the agent requests only in cycles that follow a sampled active-video qualifier. In the continuous policy it requests every cycle. Outside active video it then sends luma at the clamp level and chroma at zero bias, in place of the incoming samples. A drive-mode input chooses whether the enable is held for the whole clock period or only for the clock-high half. The half-cycle setting is for buses that carry several sources.

Top module: `prio_bus_master`

## Requirements
- R1: While rst_ni is low, prio_req_o is 0, prio_id_o is 0 and data_oe_o is 0.
- R2: When arb_en_i is 0 at a rising edge, prio_req_o is 0 and data_oe_o is 0 for the cycle that follows, whatever the mode and qualifier.
- R3: With req_mode_i = 0 (gated), prio_req_o after an edge equals av_i sampled at that edge, ANDed with arb_en_i. prio_id_o carries my_id_i while prio_req_o is 1 and is 0 otherwise.
- R4: With req_mode_i = 1 (continuous) and arb_en_i = 1, prio_req_o is 1 after every edge, independent of av_i.
- R5: When av_i is 0 at an edge, y_o becomes Y_CLAMP (default 16) and c_o becomes C_BIAS (default 0, two's complement) from that edge on.
- R6: When av_i is 1 at an edge, y_o and c_o take y_i and c_i sampled at that edge.
- R7: data_oe_o is 1 during a cycle only if prio_req_o is 1 and prio_bus_i equals my_id_i in that same cycle. The grant takes effect in the cycle in which the request is driven.
- R8: With half_drive_i = 1, data_oe_o is 0 while clk_i is low, even with a grant. With half_drive_i = 0, a grant holds data_oe_o high through both clock phases.
- R9: When the resolved lane value differs from my_id_i, data_oe_o stays 0. This covers the case where a wired-OR of two codes forms a third code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arb_en_i | input | 1 | Global enable for arbitration requests |
| req_mode_i | input | 1 | 0 = requests gated by active video, 1 = continuous requests |
| half_drive_i | input | 1 | 1 = drive only during clock-high half, 0 = full period |
| my_id_i | input | 3 | This source's priority code |
| av_i | input | 1 | Active-video qualifier |
| y_i | input | 8 | Incoming luma sample |
| c_i | input | 8 | Incoming chroma sample |
| prio_bus_i | input | 3 | Resolved priority lane value |
| prio_req_o | output | 1 | Request is being driven this cycle |
| prio_id_o | output | 3 | Code driven onto the priority lane (0 when idle) |
| y_o | output | 8 | Registered luma to the bus |
| c_o | output | 8 | Registered chroma to the bus |
| data_oe_o | output | 1 | Output-enable for y_o and c_o (0 means high impedance) |

## Verification
The bench places a second agent's code on the wired-OR lane next to this block's code 5. A rival code of 0 shows a plain win. Code 4 shows a win when the OR still equals 5. Codes 2 and 6 show a collision in which the OR forms 7 and nobody wins. The same request is sampled in the clock-high and clock-low phases under both drive settings, which separates half-cycle gating from full-cycle drive. Active-video high and low are applied under both request policies. This separates gated requesting from continuous requesting, and separates sample pass-through from clamp/bias substitution.

// File: rtl/prio_bus_pkg.sv
package prio_bus_pkg;
  typedef enum logic {
    REQ_GATED = 1'b0,
    REQ_CONT  = 1'b1
  } req_mode_e;
endpackage

// File: rtl/prio_req_gen.sv
module prio_req_gen
  import prio_bus_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arb_en_i,
  input  req_mode_e       mode_i,
  input  logic            av_i,
  input  logic [ID_W-1:0] my_id_i,
  output logic            req_o,
  output logic [ID_W-1:0] id_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= arb_en_i && ((mode_i == REQ_CONT) || av_i);
  end

  assign req_o = req_q;
  assign id_o  = req_q ? my_id_i : '0;

  assert_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arb_en_i |=> !req_o);
  assert_cont_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_en_i && mode_i == REQ_CONT) |=> req_o);
  assert_gated_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == REQ_GATED && !av_i) |=> (id_o == '0));
endmodule

// File: rtl/prio_data_reg.sv
module prio_data_reg #(
  parameter int          DW    = 8,
  parameter logic [DW-1:0] CLAMP = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          av_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= CLAMP;
    else         q_o <= av_i ? d_i : CLAMP;
  end

  assert_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !av_i |=> (q_o == CLAMP));
  assert_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    av_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/prio_drive_ctl.sv
module prio_drive_ctl #(
  parameter int ID_W = 3
) (
  input  logic            clk_i,
  input  logic            req_i,
  input  logic            half_i,
  input  logic [ID_W-1:0] bus_i,
  input  logic [ID_W-1:0] my_id_i,
  output logic            oe_o
);
  logic grant;

  // Read-back match: only an exact echo of the own code wins.
  assign grant = req_i && (bus_i == my_id_i);
  // Half-cycle mode drives only while clock is high.
  assign oe_o  = grant && (!half_i || clk_i);
endmodule

// File: rtl/prio_bus_master.sv
module prio_bus_master
  import prio_bus_pkg::*;
#(
  parameter int            ID_W    = 3,
  parameter int            DW      = 8,
  parameter logic [DW-1:0] Y_CLAMP = 8'd16,
  parameter logic [DW-1:0] C_BIAS  = 8'd0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arb_en_i,
  input  logic            req_mode_i,
  input  logic            half_drive_i,
  input  logic [ID_W-1:0] my_id_i,
  input  logic            av_i,
  input  logic [DW-1:0]   y_i,
  input  logic [DW-1:0]   c_i,
  input  logic [ID_W-1:0] prio_bus_i,
  output logic            prio_req_o,
  output logic [ID_W-1:0] prio_id_o,
  output logic [DW-1:0]   y_o,
  output logic [DW-1:0]   c_o,
  output logic            data_oe_o
);
  req_mode_e mode;
  assign mode = req_mode_e'(req_mode_i);

  prio_req_gen #(.ID_W(ID_W)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arb_en_i(arb_en_i),
    .mode_i  (mode),
    .av_i    (av_i),
    .my_id_i (my_id_i),
    .req_o   (prio_req_o),
    .id_o    (prio_id_o)
  );

  prio_data_reg #(.DW(DW), .CLAMP(Y_CLAMP)) u_luma (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .av_i  (av_i),
    .d_i   (y_i),
    .q_o   (y_o)
  );

  prio_data_reg #(.DW(DW), .CLAMP(C_BIAS)) u_chroma (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .av_i  (av_i),
    .d_i   (c_i),
    .q_o   (c_o)
  );

  prio_drive_ctl #(.ID_W(ID_W)) u_drv (
    .clk_i  (clk_i),
    .req_i  (prio_req_o),
    .half_i (half_drive_i),
    .bus_i  (prio_bus_i),
    .my_id_i(my_id_i),
    .oe_o   (data_oe_o)
  );

  assert_grant_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (prio_req_o && prio_bus_i == prio_id_o));
  assert_mismatch_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_bus_i != my_id_i) |-> !data_oe_o);
endmodule

// File: tb/prio_bus_master_tb_top.sv
module prio_bus_master_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       arb_en_i = 1'b0;
  logic       req_mode_i = 1'b0;
  logic       half_drive_i = 1'b0;
  logic [2:0] my_id_i = 3'd5;
  logic       av_i = 1'b0;
  logic [7:0] y_i = 8'h00;
  logic [7:0] c_i = 8'h00;
  logic [2:0] rival = 3'd0;
  logic [2:0] prio_bus;
  logic       prio_req_o;
  logic [2:0] prio_id_o;
  logic [7:0] y_o, c_o;
  logic       data_oe_o;
  logic       oe_hi, oe_lo;
  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  // Wired-OR lane resolution of all agents.
  assign prio_bus = prio_id_o | rival;

  prio_bus_master dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arb_en_i(arb_en_i), .req_mode_i(req_mode_i),
    .half_drive_i(half_drive_i), .my_id_i(my_id_i), .av_i(av_i), .y_i(y_i), .c_i(c_i),
    .prio_bus_i(prio_bus), .prio_req_o(prio_req_o), .prio_id_o(prio_id_o),
    .y_o(y_o), .c_o(c_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic mode, input logic half,
                       input logic av, input logic [7:0] y, input logic [7:0] c,
                       input logic [2:0] riv);
    arb_en_i = en; req_mode_i = mode; half_drive_i = half;
    av_i = av; y_i = y; c_i = c; rival = riv;
  endtask

  // Edge, then sample in the high phase and in the low phase.
  task automatic tick();
    @(posedge clk_i);
    #4  oe_hi = data_oe_o;
    #8  oe_lo = data_oe_o;
  endtask

  task automatic t_reset();
    #50;
    chk("R1 req", prio_req_o, 0);
    chk("R1 id", prio_id_o, 0);
    chk("R1 oe", data_oe_o, 0);
    @(posedge clk_i); #12 rst_ni = 1'b1;
  endtask

  task automatic t_disabled();
    apply(0, 1, 0, 1, 8'h55, 8'h11, 0); tick();
    chk("R2 req", prio_req_o, 0);
    chk("R2 oe", oe_hi, 0);
    apply(0, 0, 0, 1, 8'h55, 8'h11, 0); tick();
    chk("R2 req gated", prio_req_o, 0);
  endtask

  task automatic t_gated();
    apply(1, 0, 0, 1, 8'hA3, 8'h7C, 0); tick();
    chk("R3 req", prio_req_o, 1);
    chk("R3 id", prio_id_o, 5);
    chk("R7 oe hi", oe_hi, 1);
    chk("R7 oe lo", oe_lo, 1);
    chk("R6 y", y_o, 8'hA3);
    chk("R6 c", c_o, 8'h7C);
    apply(1, 0, 0, 0, 8'hA3, 8'h7C, 0); tick();
    chk("R3 req idle", prio_req_o, 0);
    chk("R3 id idle", prio_id_o, 0);
    chk("R7 oe idle", oe_hi, 0);
  endtask

  task automatic t_continuous();
    apply(1, 1, 0, 0, 8'hC8, 8'h90, 0); tick();
    chk("R4 req", prio_req_o, 1);
    chk("R4 oe", oe_hi, 1);
    chk("R5 y clamp", y_o, 16);
    chk("R5 c bias", c_o, 0);
    apply(1, 1, 0, 1, 8'h80, 8'hF0, 0); tick();
    chk("R6 y", y_o, 8'h80);
    chk("R6 c", c_o, 8'hF0);
    chk("R4 req av", prio_req_o, 1);
  endtask

  task automatic t_rivals();
    apply(1, 1, 0, 1, 8'h20, 8'h01, 3'd2); tick();
    chk("R9 or 5|2", oe_hi, 0);
    apply(1, 1, 0, 1, 8'h20, 8'h01, 3'd4); tick();
    chk("R7 or 5|4", oe_hi, 1);
    apply(1, 1, 0, 1, 8'h20, 8'h01, 3'd6); tick();
    chk("R9 or 5|6", oe_hi, 0);
    chk("R9 oe lo", oe_lo, 0);
  endtask

  task automatic t_half();
    apply(1, 1, 1, 1, 8'h40, 8'h02, 0); tick();
    chk("R8 half hi", oe_hi, 1);
    chk("R8 half lo", oe_lo, 0);
    apply(1, 1, 0, 1, 8'h40, 8'h02, 0); tick();
    chk("R8 full hi", oe_hi, 1);
    chk("R8 full lo", oe_lo, 1);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_gated();
    t_continuous();
    t_rivals();
    t_half();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule